// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block sits between eight interrupt request lines and a processor. Requests are captured into a pending register, filtered by a software-loaded mask, and ranked against the levels already being serviced. When a pending unmasked line outranks everything in service, the block raises its interrupt output. An acknowledge pulse moves the winner from pending into service and publishes its 3-bit level code. An end-of-service command retires the top in-service level.

Ranking is circular around a "lowest line" pointer. In fixed mode the pointer is pinned to line 7, so line 0 always wins. In auto-rotate mode each end-of-service moves the pointer onto the level just retired, so that level drops to the bottom. In specific mode the pointer is set only by a software command. Software uses a one-byte write port. Address 1 loads the mask. Address 0 carries a command byte that also loads the mode.

Top module: `irq_resolver`

## Requirements
- R1: After reset, int_o is 0, in_service_o is 0, level_o is 0 and the mask is all zero. The mode is fixed and the lowest line is 7.
- R2: A request held high for a single clock stays pending until it is acknowledged. int_o rises in the cycle after the capturing edge.
- R3: In fixed mode line 0 ranks highest and line 7 lowest. An acknowledge while int_o is 1 clears the winner's pending bit and sets its in-service bit. It also loads level_o with the winner's line number.
- R4: A write with wr_addr_i=1 loads the mask from wr_data_i[7:0]. While mask bit i is 1, line i takes no part in ranking. Clearing the bit lets a still-pending request compete again.
- R5: int_o is 1 only when some pending unmasked line ranks strictly above every in-service level. A line of equal or lower rank waits.
- R6: An acknowledge while int_o is 0 leaves in_service_o and level_o unchanged.
- R7: A write with wr_addr_i=0 and wr_data_i[7]=1 is an end-of-service. It clears the highest-ranked in-service bit.
- R8: Every address-0 write loads the mode from wr_data_i[5:4]: 00 fixed, 01 auto-rotate, 10 specific, 11 treated as fixed. In auto-rotate, an end-of-service also moves the lowest-line pointer to the level it cleared.
- R9: An address-0 write with wr_data_i[6]=1 sets the lowest-line pointer to wr_data_i[2:0]. This takes precedence over R8 in the same write. In auto-rotate and specific modes, ranking runs circularly from pointer+1 (highest) to the pointer (lowest). In fixed mode the pointer has no effect.
- R10: In the cycle after an accepted acknowledge, int_o is 0 unless another pending unmasked line outranks every in-service level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Request lines, captured on each rising edge |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 1 = mask, 0 = mode/command byte |
| wr_data_i | input | 8 | Write data |
| int_o | output | 1 | Interrupt request to the processor |
| level_o | output | 3 | Line number of the last accepted acknowledge |
| in_service_o | output | 8 | Levels currently in service |

## Verification
The pending, in-service, mask, mode, pointer and level state is all registered. Each stimulus therefore shows up at the outputs one edge later. A request, an acknowledge or a write applied before edge t is visible on int_o, level_o and in_service_o just after edge t, and int_o has no path from any input. The bench drives inputs and samples outputs on the falling edge. A behavioural reference model steps on each rising edge and is compared against all three outputs every cycle. Directed checks with hand-computed values cover the nesting, masking and the three rotation modes.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  typedef enum logic [1:0] {
    PRI_FIXED    = 2'b00,
    PRI_AUTO     = 2'b01,
    PRI_SPECIFIC = 2'b10,
    PRI_RSVD     = 2'b11
  } pri_mode_e;

  localparam int unsigned DATA_W       = 8;
  localparam int unsigned CMD_EOS_BIT  = 7;
  localparam int unsigned CMD_SETLO_BIT = 6;
  localparam int unsigned CMD_MODE_LSB = 4;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] lowest_i,
  output logic          found_o,
  output logic [LW-1:0] win_o,
  output logic [LW-1:0] rank_o
);
  // rank 0 = line just after lowest_i; scan downward so the smallest rank wins
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(lowest_i) + 1 + k) % N;
      if (vec_i[idx]) begin
        found_o = 1'b1;
        win_o   = LW'(idx);
        rank_o  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_resolver_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              top_isr_valid_i,
  input  logic [LW-1:0]     top_isr_lvl_i,
  output logic [N-1:0]      mask_o,
  output pri_mode_e         mode_o,
  output logic [LW-1:0]     eff_lowest_o,
  output logic              eos_o
);
  logic [LW-1:0] lowest_q;
  pri_mode_e     mode_d;
  logic          cmd_wr, setlo;

  assign cmd_wr = wr_en_i && !wr_addr_i;
  assign eos_o  = cmd_wr && wr_data_i[CMD_EOS_BIT];
  assign setlo  = cmd_wr && wr_data_i[CMD_SETLO_BIT];
  assign mode_d = pri_mode_e'(wr_data_i[CMD_MODE_LSB +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      mode_o   <= PRI_FIXED;
      lowest_q <= LW'(N - 1);
    end else begin
      if (wr_en_i && wr_addr_i) mask_o <= wr_data_i[N-1:0];
      if (cmd_wr) mode_o <= mode_d;
      if (setlo)
        lowest_q <= wr_data_i[LW-1:0];
      else if (eos_o && mode_d == PRI_AUTO && top_isr_valid_i)
        lowest_q <= top_isr_lvl_i;
    end
  end

  assign eff_lowest_o = (mode_o == PRI_AUTO || mode_o == PRI_SPECIFIC) ? lowest_q : LW'(N - 1);

  p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i |=> mask_o == $past(wr_data_i[N-1:0]));

  p_rotate_on_eos_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o && !setlo && mode_d == PRI_AUTO && top_isr_valid_i |=> eff_lowest_o == $past(top_isr_lvl_i));

  p_setlo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setlo && mode_d == PRI_SPECIFIC |=> eff_lowest_o == $past(wr_data_i[LW-1:0]));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolver_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      irq_req_i,
  input  logic              ack_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              int_o,
  output logic [LW-1:0]     level_o,
  output logic [N-1:0]      in_service_o
);
  logic [N-1:0]  irr_q, isr_q, mask;
  pri_mode_e     mode;
  logic [LW-1:0] eff_lowest;
  logic          eos;
  logic          req_found, isr_found, take;
  logic [LW-1:0] req_win, req_rank, isr_win, isr_rank;
  logic [N-1:0]  take_vec, eos_vec;

  irq_cfg_regs #(.N(N), .LW(LW)) u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .top_isr_valid_i(isr_found),
    .top_isr_lvl_i  (isr_win),
    .mask_o         (mask),
    .mode_o         (mode),
    .eff_lowest_o   (eff_lowest),
    .eos_o          (eos)
  );

  irq_pick #(.N(N), .LW(LW)) u_pick_req (
    .vec_i   (irr_q & ~mask),
    .lowest_i(eff_lowest),
    .found_o (req_found),
    .win_o   (req_win),
    .rank_o  (req_rank)
  );

  irq_pick #(.N(N), .LW(LW)) u_pick_isr (
    .vec_i   (isr_q),
    .lowest_i(eff_lowest),
    .found_o (isr_found),
    .win_o   (isr_win),
    .rank_o  (isr_rank)
  );

  // strictly higher than every in-service level
  assign int_o    = req_found && (!isr_found || req_rank < isr_rank);
  assign take     = ack_i && int_o;
  assign take_vec = take ? (N'(1) << req_win) : '0;
  assign eos_vec  = (eos && isr_found) ? (N'(1) << isr_win) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q   <= '0;
      isr_q   <= '0;
      level_o <= '0;
    end else begin
      irr_q <= (irr_q | irq_req_i) & ~take_vec;
      isr_q <= (isr_q & ~eos_vec) | take_vec;
      if (take) level_o <= req_win;
    end
  end

  assign in_service_o = isr_q;

  p_ack_enters_service_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> in_service_o[level_o]);

  p_ack_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(level_o));

  p_isr_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take && !eos |=> $stable(in_service_o));

  p_eos_retires_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos && !take && isr_found |=> $countones(in_service_o) == $past($countones(in_service_o)) - 1);

  p_service_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !eos |=> $countones(in_service_o) == $past($countones(in_service_o)) + 1);
endmodule

// File: tb/irq_resolver_bench.sv
module irq_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       ack = 1'b0;
  logic       wen = 1'b0;
  logic       waddr = 1'b0;
  logic [7:0] wdata = '0;
  logic       int_o;
  logic [2:0] level;
  logic [7:0] isr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_resolver u_irq_resolver (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .ack_i(ack),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .int_o(int_o), .level_o(level), .in_service_o(isr)
  );

  // reference model
  bit [7:0] m_irr, m_isr, m_mask;
  int m_mode, m_low, m_level;

  function automatic int rank_of(int line, int lo);
    return (line - lo - 1 + 16) % 8;
  endfunction

  function automatic int eff_low();
    return (m_mode == 1 || m_mode == 2) ? m_low : 7;
  endfunction

  function automatic int best(bit [7:0] v, int lo);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || rank_of(i, lo) < rank_of(b, lo))) b = i;
    return b;
  endfunction

  function automatic bit m_int();
    int lo = eff_low();
    int r = best(m_irr & ~m_mask, lo);
    int s = best(m_isr, lo);
    return (r >= 0) && (s < 0 || rank_of(r, lo) < rank_of(s, lo));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_mask = '0;
      m_mode = 0; m_low = 7; m_level = 0;
    end else begin
      int lo, r, s, nmode;
      bit [7:0] nirr, nisr;
      lo = eff_low();
      r = best(m_irr & ~m_mask, lo);
      s = best(m_isr, lo);
      nirr = m_irr | req;
      nisr = m_isr;
      nmode = m_mode;
      if (wen && !waddr && wdata[7] && s >= 0) nisr[s] = 1'b0;
      if (ack && m_int()) begin
        nirr[r] = 1'b0;
        nisr[r] = 1'b1;
        m_level = r;
      end
      if (wen && waddr) m_mask = wdata;
      if (wen && !waddr) begin
        nmode = int'(wdata[5:4]);
        if (wdata[6]) m_low = int'(wdata[2:0]);
        else if (wdata[7] && nmode == 1 && s >= 0) m_low = s;
      end
      m_mode = nmode;
      m_irr = nirr;
      m_isr = nisr;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int_o === m_int(), "R5 model int_o", int'(int_o), int'(m_int()));
      chk(level === 3'(m_level), "R3 model level_o", int'(level), m_level);
      chk(isr === m_isr, "R7 model in_service_o", int'(isr), int'(m_isr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input logic [7:0] v);
    req = v; @(negedge clk); req = '0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wen = 1'b1; waddr = a; wdata = d; @(negedge clk); wen = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int_o === 1'b0 && isr === 8'h00 && level === 3'd0, "R1 reset state", int'({int_o, isr, level}), 0);

    pulse(8'h24);
    @(negedge clk);
    chk(int_o === 1'b1, "R2 one-cycle request held", int'(int_o), 1);
    do_ack();
    chk(level === 3'd2, "R3 fixed order winner", int'(level), 2);
    chk(isr === 8'h04, "R3 in-service set", int'(isr), 4);
    chk(int_o === 1'b0, "R10 int drops after ack", int'(int_o), 0);
    chk(int_o === 1'b0, "R5 lower level waits", int'(int_o), 0);

    do_ack();
    chk(isr === 8'h04 && level === 3'd2, "R6 ack ignored", int'({isr, level}), 'h04 << 3 | 2);

    wr(1'b0, 8'h80);
    chk(isr === 8'h00 && int_o === 1'b1, "R7 eos clears", int'({isr, int_o}), 1);
    do_ack();
    chk(level === 3'd5, "R3 next winner", int'(level), 5);
    wr(1'b0, 8'h80);

    wr(1'b1, 8'h08);
    pulse(8'h08);
    chk(int_o === 1'b0, "R4 masked line silent", int'(int_o), 0);
    wr(1'b1, 8'h00);
    chk(int_o === 1'b1, "R4 unmask lets pending compete", int'(int_o), 1);
    do_ack();
    chk(level === 3'd3, "R4 unmasked winner", int'(level), 3);
    wr(1'b0, 8'h80);

    pulse(8'h10);
    do_ack();
    pulse(8'h02);
    chk(int_o === 1'b1, "R5 higher level preempts", int'(int_o), 1);
    do_ack();
    chk(level === 3'd1 && isr === 8'h12, "R5 nested service", int'({isr, level}), 'h12 << 3 | 1);
    wr(1'b0, 8'h80);
    chk(isr === 8'h10, "R7 top in-service cleared", int'(isr), 'h10);
    wr(1'b0, 8'h80);

    wr(1'b0, 8'h10);
    pulse(8'h08);
    do_ack();
    wr(1'b0, 8'h90);
    pulse(8'h21);
    do_ack();
    chk(level === 3'd5, "R8 rotated order favours line 5", int'(level), 5);
    wr(1'b0, 8'h90);
    do_ack();
    chk(level === 3'd0, "R8 second rotation", int'(level), 0);
    wr(1'b0, 8'h90);

    wr(1'b0, 8'h66);
    pulse(8'hC0);
    do_ack();
    chk(level === 3'd7, "R9 specific lowest 6", int'(level), 7);
    wr(1'b0, 8'hA0);
    do_ack();
    chk(level === 3'd6, "R9 lowest served last", int'(level), 6);
    wr(1'b0, 8'hA0);
    pulse(8'h81);
    do_ack();
    chk(level === 3'd7, "R9 pointer kept in specific", int'(level), 7);
    wr(1'b0, 8'hA0);
    do_ack();
    wr(1'b0, 8'hA0);

    wr(1'b0, 8'h46);
    pulse(8'hC0);
    do_ack();
    chk(level === 3'd6, "R9 fixed ignores pointer", int'(level), 6);
    wr(1'b0, 8'h80);
    do_ack();
    wr(1'b0, 8'h80);
    chk(isr === 8'h00 && int_o === 1'b0, "R7 all retired", int'({isr, int_o}), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule